// File: doc/BRIEF.md
# Flag-Setting Add With Extended Second Operand

This unit is the combinational datapath for one integer add that also produces condition flags. It takes a 32-bit instruction word and splits it into its fields: the width select, the two source register indices, the destination index, the extension mode and the shift amount. It hands the source indices to the register file and receives the two register values and the current stack pointer back from it. The first operand is the general register named by the base index. When that index is 31, the stack pointer is used in its place.

The second operand is built in three steps. A byte, halfword, word or doubleword is taken from the low end of the offset register. That slice is sign- or zero-extended to the full width. The extended value is then shifted left by zero to four places. The unit adds the two operands with no carry in and returns the sum together with the negative, zero, carry and overflow flags. In narrow mode, all of this is done at 32 bits.

An instruction word that does not carry the expected fixed opcode bits, or that asks for a shift above four, raises an undefined flag. The arithmetic outputs are still driven in that case, but the caller is expected to discard them.

Top module: `xadd_ext_unit`

## Requirements
- R1: The word is decoded as bit 31 = width select (1 wide, 0 narrow), bits 20:16 = offset register index, 15:13 = extension mode, 12:10 = shift amount, 9:5 = base register index, 4:0 = destination index. The three indices appear unchanged on their output ports.
- R2: When extension-mode bit 2 is 0, the low byte, halfword, word or whole offset register (mode bits 1:0 = 00, 01, 10, 11) is zero-extended.
- R3: When extension-mode bit 2 is 1, the same slice is sign-extended from its top bit.
- R4: The extended value is shifted left by the shift amount (0 to 4), so the shifted-in low bits are zero.
- R5: The undefined flag is 1 when bits 30:21 differ from 0101011001 or when the shift amount is 5, 6 or 7. Otherwise it is 0.
- R6: A base index of 31 selects the stack pointer value as the first operand. Any other index selects the base register value.
- R7: In wide mode, the result is the sum of the two 64-bit operands modulo 2^64.
- R8: The negative flag equals the top bit of the result at the active width. The zero flag is 1 exactly when that result is all zeros.
- R9: The carry flag is the unsigned carry out of the top bit of the active width.
- R10: The overflow flag is 1 when two operands of equal sign give a result of the opposite sign at the active width.
- R11: In narrow mode, both operands are cut to their low 32 bits, all flags are taken at bit 31, and result bits 63:32 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_insn | input | 32 | Instruction word |
| i_base_val | input | 64 | Value read from the base register |
| i_ofs_val | input | 64 | Value read from the offset register |
| i_sp_val | input | 64 | Current stack pointer |
| o_base_idx | output | 5 | Base register read index |
| o_ofs_idx | output | 5 | Offset register read index |
| o_dst_idx | output | 5 | Destination register index |
| o_result | output | 64 | Sum, zero-extended in narrow mode |
| o_neg | output | 1 | Negative flag |
| o_zero | output | 1 | Zero flag |
| o_carry | output | 1 | Carry flag |
| o_ovf | output | 1 | Overflow flag |
| o_undef | output | 1 | Undefined encoding or reserved shift |

## Verification
Random words with a valid opcode and random register values exercise every pairing of slice size, extension sign, shift and width. Offset values are drawn so that their slice top bits vary, which separates sign filling from zero filling. Directed words cover the following cases:
- an all-ones plus one sum, which shows carry and zero without overflow;
- a largest-positive plus one sum, which shows overflow without carry;
- a narrow add whose operand upper halves are nonzero, which shows the truncation and the flag width;
- a base index of 31 with a distinct stack pointer value;
- shift amounts at 4 and at 5 and 7, plus a corrupted opcode bit, to mark where the undefined flag starts.

// File: rtl/xadd_pkg.sv
package xadd_pkg;

   localparam int IDX_W  = 5;
   localparam int SH_W   = 3;
   localparam int WORD_W = 32;

   // fixed opcode bits 30:21 of the decoded word
   localparam logic [9:0] FIXED_OPC = 10'b0101011001;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_DBL  = 2'b11
   } ext_size_e;

   typedef struct packed {
      logic             wide;
      logic [IDX_W-1:0] ofs_idx;
      logic             sgn;
      ext_size_e        size;
      logic [SH_W-1:0]  shamt;
      logic [IDX_W-1:0] base_idx;
      logic [IDX_W-1:0] dst_idx;
   } xadd_fields_t;

endpackage

// File: rtl/xadd_decode.sv
module xadd_decode
   import xadd_pkg::*;
#(
   parameter int INSN_W    = 32,
   parameter int MAX_SHIFT = 4
) (
   input  logic [INSN_W-1:0] i_insn,
   output xadd_fields_t      o_fields,
   output logic              o_undef
);

   localparam int OPC_LO = 21;
   localparam int OPC_HI = OPC_LO + $bits(FIXED_OPC) - 1;

   initial begin
      assert (INSN_W == 32) else $fatal(1, "xadd_decode: word width must be 32");
      assert (MAX_SHIFT < (1 << SH_W)) else $fatal(1, "xadd_decode: shift limit too wide");
   end

   logic opc_bad;
   logic sh_bad;

   always_comb begin
      o_fields.wide     = i_insn[31];
      o_fields.ofs_idx  = i_insn[20:16];
      o_fields.sgn      = i_insn[15];
      o_fields.size     = ext_size_e'(i_insn[14:13]);
      o_fields.shamt    = i_insn[12:10];
      o_fields.base_idx = i_insn[9:5];
      o_fields.dst_idx  = i_insn[4:0];
   end

   assign opc_bad = (i_insn[OPC_HI:OPC_LO] != FIXED_OPC);
   assign sh_bad  = (int'(i_insn[12:10]) > MAX_SHIFT);
   assign o_undef = opc_bad | sh_bad;

   // R5: a shift beyond the limit is never accepted
   always_comb begin
      if (int'(o_fields.shamt) > MAX_SHIFT)
         a_r5_reserved_shift: assert (o_undef) else $error("R5: reserved shift accepted");
   end

endmodule

// File: rtl/xadd_operand.sv
module xadd_operand
   import xadd_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] i_src,
   input  ext_size_e       i_size,
   input  logic            i_signed,
   input  logic [SH_W-1:0] i_shamt,
   output logic [XLEN-1:0] o_opnd
);

   localparam int NSZ = 4;

   initial begin
      assert (XLEN >= 64) else $fatal(1, "xadd_operand: XLEN must hold a doubleword");
   end

   logic [XLEN-1:0] cand [NSZ];
   logic [XLEN-1:0] ext_val;
   logic [XLEN-1:0] low_mask;

   for (genvar k = 0; k < NSZ; k++) begin : g_lane
      localparam int LW = 8 << k;
      logic [LW-1:0] part;
      assign part = i_src[LW-1:0];
      if (LW < XLEN) begin : g_fill
         logic fill;
         assign fill    = i_signed & part[LW-1];
         assign cand[k] = {{(XLEN-LW){fill}}, part};
      end else begin : g_full
         assign cand[k] = part;
      end
   end

   assign ext_val  = cand[i_size];
   assign o_opnd   = ext_val << i_shamt;
   assign low_mask = ~({XLEN{1'b1}} << i_shamt);

   always_comb begin
      // R4: shifted-in positions are clear
      a_r4_low_clear: assert ((o_opnd & low_mask) == '0) else $error("R4: low bits set");
      // R3: a negative byte fills the top when unshifted
      if (i_signed && i_size == SZ_BYTE && i_src[7] && i_shamt == '0)
         a_r3_sign_fill: assert (o_opnd[XLEN-1]) else $error("R3: sign fill missing");
      // R2: zero extension of a short slice leaves the top clear
      if (!i_signed && i_size != SZ_DBL && i_shamt == '0)
         a_r2_zero_fill: assert (!o_opnd[XLEN-1]) else $error("R2: top bit set");
   end

endmodule

// File: rtl/xadd_core.sv
module xadd_core #(
   parameter int W = 64
) (
   input  logic [W-1:0] i_a,
   input  logic [W-1:0] i_b,
   output logic [W-1:0] o_sum,
   output logic         o_neg,
   output logic         o_zero,
   output logic         o_carry,
   output logic         o_ovf
);

   initial begin
      assert (W >= 2) else $fatal(1, "xadd_core: width too small");
   end

   logic [W:0] wide_sum;

   assign wide_sum = {1'b0, i_a} + {1'b0, i_b};
   assign o_sum    = wide_sum[W-1:0];
   assign o_carry  = wide_sum[W];
   assign o_neg    = o_sum[W-1];
   assign o_zero   = ~|o_sum;
   assign o_ovf    = (i_a[W-1] == i_b[W-1]) && (o_sum[W-1] != i_a[W-1]);

   always_comb begin
      // R9: a carry out means the sum wrapped below the first operand
      a_r9_carry_wrap: assert (o_carry == (o_sum < i_a)) else $error("R9: carry mismatch");
      // R10: overflow always flips the sign against the first operand
      if (o_ovf)
         a_r10_ovf_sign: assert (o_sum[W-1] != i_a[W-1]) else $error("R10: bad overflow");
   end

endmodule

// File: rtl/xadd_ext_unit.sv
module xadd_ext_unit
   import xadd_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int MAX_SHIFT = 4
) (
   input  logic [31:0]      i_insn,
   input  logic [XLEN-1:0]  i_base_val,
   input  logic [XLEN-1:0]  i_ofs_val,
   input  logic [XLEN-1:0]  i_sp_val,
   output logic [IDX_W-1:0] o_base_idx,
   output logic [IDX_W-1:0] o_ofs_idx,
   output logic [IDX_W-1:0] o_dst_idx,
   output logic [XLEN-1:0]  o_result,
   output logic             o_neg,
   output logic             o_zero,
   output logic             o_carry,
   output logic             o_ovf,
   output logic             o_undef
);

   localparam int NW = WORD_W;
   localparam logic [IDX_W-1:0] SP_IDX = '1;

   initial begin
      assert (XLEN == 2 * NW) else $fatal(1, "xadd_ext_unit: XLEN must be twice the narrow width");
   end

   xadd_fields_t     f;
   logic [XLEN-1:0]  op1;
   logic [XLEN-1:0]  op2;
   logic [XLEN-1:0]  sum_w;
   logic [NW-1:0]    sum_n;
   logic             n_w, z_w, c_w, v_w;
   logic             n_n, z_n, c_n, v_n;

   xadd_decode #(.INSN_W(32), .MAX_SHIFT(MAX_SHIFT)) i_dec (
      .i_insn   (i_insn),
      .o_fields (f),
      .o_undef  (o_undef)
   );

   assign op1 = (f.base_idx == SP_IDX) ? i_sp_val : i_base_val;

   xadd_operand #(.XLEN(XLEN)) i_opnd (
      .i_src    (i_ofs_val),
      .i_size   (f.size),
      .i_signed (f.sgn),
      .i_shamt  (f.shamt),
      .o_opnd   (op2)
   );

   xadd_core #(.W(XLEN)) i_add_wide (
      .i_a (op1), .i_b (op2), .o_sum (sum_w),
      .o_neg (n_w), .o_zero (z_w), .o_carry (c_w), .o_ovf (v_w)
   );

   xadd_core #(.W(NW)) i_add_narrow (
      .i_a (op1[NW-1:0]), .i_b (op2[NW-1:0]), .o_sum (sum_n),
      .o_neg (n_n), .o_zero (z_n), .o_carry (c_n), .o_ovf (v_n)
   );

   always_comb begin
      if (f.wide) begin
         o_result = sum_w;
         {o_neg, o_zero, o_carry, o_ovf} = {n_w, z_w, c_w, v_w};
      end else begin
         o_result = {{(XLEN-NW){1'b0}}, sum_n};
         {o_neg, o_zero, o_carry, o_ovf} = {n_n, z_n, c_n, v_n};
      end
   end

   assign o_base_idx = f.base_idx;
   assign o_ofs_idx  = f.ofs_idx;
   assign o_dst_idx  = f.dst_idx;

   always_comb begin
      // R6: base index 31 routes the stack pointer
      if (o_base_idx == SP_IDX)
         a_r6_sp_base: assert (op1 == i_sp_val) else $error("R6: stack pointer not used");
      // R11: narrow results keep the upper half clear
      if (!i_insn[31])
         a_r11_upper_zero: assert (o_result[XLEN-1:NW] == '0) else $error("R11: upper half set");
      // R8: zero flag agrees with the delivered result
      if (o_zero)
         a_r8_zero_result: assert (o_result == '0) else $error("R8: zero flag with nonzero result");
   end

endmodule

// File: tb/test_xadd_ext_unit.sv
module test_xadd_ext_unit;

   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 400;

   logic        clk = 1'b0;
   logic [31:0] insn;
   logic [63:0] base_val, ofs_val, sp_val;
   logic [4:0]  base_idx, ofs_idx, dst_idx;
   logic [63:0] result;
   logic        neg, zero, carry, ovf, undef;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xadd_ext_unit i_xadd_ext_unit (
      .i_insn (insn), .i_base_val (base_val), .i_ofs_val (ofs_val), .i_sp_val (sp_val),
      .o_base_idx (base_idx), .o_ofs_idx (ofs_idx), .o_dst_idx (dst_idx),
      .o_result (result), .o_neg (neg), .o_zero (zero), .o_carry (carry),
      .o_ovf (ovf), .o_undef (undef)
   );

   function automatic logic [31:0] enc(input logic sf, input logic [4:0] rm, input logic [2:0] opt,
                                       input logic [2:0] sh, input logic [4:0] rn, input logic [4:0] rd);
      return {sf, 10'b0101011001, rm, opt, sh, rn, rd};
   endfunction

   function automatic logic [63:0] m_ext(input logic [63:0] v, input logic [2:0] opt, input logic [2:0] sh);
      logic [63:0] e;
      case (opt)
         3'b000: e = {56'd0, v[7:0]};
         3'b001: e = {48'd0, v[15:0]};
         3'b010: e = {32'd0, v[31:0]};
         3'b100: e = 64'($signed(v[7:0]));
         3'b101: e = 64'($signed(v[15:0]));
         3'b110: e = 64'($signed(v[31:0]));
         default: e = v;
      endcase
      return e << sh;
   endfunction

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] w, input logic [63:0] b, input logic [63:0] o,
                        input logic [63:0] s, input string tag);
      logic [63:0] a1, a2, r;
      logic        sf, xn, xz, xc, xv, xu;
      logic signed [64:0] ss;
      logic signed [32:0] sn;
      logic [64:0] us;
      logic [32:0] un;
      @(negedge clk);
      insn = w; base_val = b; ofs_val = o; sp_val = s;
      sf = w[31];
      a1 = (w[9:5] == 5'd31) ? s : b;
      a2 = m_ext(o, w[15:13], w[12:10]);
      xu = (w[30:21] != 10'b0101011001) || (w[12:10] > 3'd4);
      if (sf) begin
         us = {1'b0, a1} + {1'b0, a2};
         ss = $signed({a1[63], a1}) + $signed({a2[63], a2});
         r  = us[63:0];
         xc = us[64];
         xv = ss[64] != ss[63];
         xn = r[63];
      end else begin
         un = {1'b0, a1[31:0]} + {1'b0, a2[31:0]};
         sn = $signed({a1[31], a1[31:0]}) + $signed({a2[31], a2[31:0]});
         r  = {32'd0, un[31:0]};
         xc = un[32];
         xv = sn[32] != sn[31];
         xn = r[31];
      end
      xz = (r == 64'd0);
      #(CLK_PERIOD/4);
      check({tag, "/R5"}, "undef", 64'(undef), 64'(xu));
      check({tag, "/R1"}, "indices", {49'd0, base_idx, ofs_idx, dst_idx},
            {49'd0, w[9:5], w[20:16], w[4:0]});
      if (!xu) begin
         check({tag, sf ? "/R7" : "/R11"}, "result", result, r);
         check({tag, "/R8"}, "neg", 64'(neg), 64'(xn));
         check({tag, "/R8"}, "zero", 64'(zero), 64'(xz));
         check({tag, "/R9"}, "carry", 64'(carry), 64'(xc));
         check({tag, "/R10"}, "ovf", 64'(ovf), 64'(xv));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed = 32'h5eed_1234;
      logic [31:0] w;
      insn = '0; base_val = '0; ofs_val = '0; sp_val = '0;
      void'($urandom(seed));

      // idle word: all zeros is not a valid encoding (R5)
      apply(32'h0, 64'h0, 64'h0, 64'h0, "idle_R5");

      // R2 zero extension of each slice, R3 sign extension of each slice
      apply(enc(1, 5'd2, 3'b000, 3'd0, 5'd1, 5'd0), 64'd0, 64'h1234_5678_9abc_ff80, 64'd0, "byte_zx_R2");
      apply(enc(1, 5'd2, 3'b100, 3'd0, 5'd1, 5'd0), 64'd0, 64'h1234_5678_9abc_ff80, 64'd0, "byte_sx_R3");
      apply(enc(1, 5'd2, 3'b101, 3'd0, 5'd1, 5'd0), 64'd5, 64'h0000_0000_0000_8001, 64'd0, "half_sx_R3");
      apply(enc(1, 5'd2, 3'b010, 3'd0, 5'd1, 5'd0), 64'd5, 64'hffff_ffff_8000_0000, 64'd0, "word_zx_R2");
      apply(enc(1, 5'd2, 3'b111, 3'd0, 5'd1, 5'd0), 64'd5, 64'h8000_0000_0000_0000, 64'd0, "dbl_R2");
      // R4 largest legal shift, then reserved ones (R5)
      apply(enc(1, 5'd2, 3'b110, 3'd4, 5'd1, 5'd3), 64'd1, 64'h0000_0000_f000_0001, 64'd0, "shift4_R4");
      apply(enc(1, 5'd2, 3'b000, 3'd5, 5'd1, 5'd3), 64'd1, 64'd1, 64'd0, "shift5_R5");
      apply(enc(0, 5'd2, 3'b000, 3'd7, 5'd1, 5'd3), 64'd1, 64'd1, 64'd0, "shift7_R5");
      apply(enc(1, 5'd2, 3'b000, 3'd0, 5'd1, 5'd3) ^ 32'h0020_0000, 64'd1, 64'd1, 64'd0, "opcode_R5");
      // R6 stack pointer as base
      apply(enc(1, 5'd4, 3'b011, 3'd0, 5'd31, 5'd7), 64'hdead, 64'd16, 64'h0000_7fff_0000_1000, "sp_R6");
      apply(enc(1, 5'd4, 3'b011, 3'd0, 5'd30, 5'd7), 64'hdead, 64'd16, 64'h0000_7fff_0000_1000, "nosp_R6");
      // R9 carry with zero result, R10 overflow
      apply(enc(1, 5'd2, 3'b011, 3'd0, 5'd1, 5'd0), 64'hffff_ffff_ffff_ffff, 64'd1, 64'd0, "carry_R9");
      apply(enc(1, 5'd2, 3'b011, 3'd0, 5'd1, 5'd0), 64'h7fff_ffff_ffff_ffff, 64'd1, 64'd0, "ovf_R10");
      // R11 narrow mode: upper halves ignored, flags at bit 31
      apply(enc(0, 5'd2, 3'b011, 3'd0, 5'd1, 5'd0), 64'hffff_ffff_7fff_ffff, 64'haaaa_aaaa_0000_0001, 64'd0, "narrow_ovf_R11");
      apply(enc(0, 5'd2, 3'b010, 3'd0, 5'd1, 5'd0), 64'h1234_5678_ffff_ffff, 64'h0000_0001_0000_0001, 64'd0, "narrow_carry_R11");

      for (int i = 0; i < N_RANDOM; i++) begin
         logic [63:0] rb, ro, rs;
         w  = enc(1'($urandom), 5'($urandom), 3'($urandom), 3'($urandom_range(0, 4)),
                  ($urandom_range(0, 7) == 0) ? 5'd31 : 5'($urandom), 5'($urandom));
         if ($urandom_range(0, 15) == 0) w[12:10] = 3'($urandom_range(5, 7));
         rb = {$urandom, $urandom};
         ro = {$urandom, $urandom};
         rs = {$urandom, $urandom};
         apply(w, rb, ro, rs, "random");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule